// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timebase

This block is a system watchdog. An 8-bit down-counter is loaded by software with a timeout count and then decrements once per time unit. The unit is picked from three widely spaced ticks that a prescaler chain derives from a fixed reference clock: a fast tick (10 ms at the default ratios), a tick 100 times slower (1 s), and one a further 60 times slower (1 min). One 8-bit count therefore covers timeouts from tens of milliseconds to more than four hours.

Software reaches the block through a two-register interface. The count register loads and starts the counter, and writing it again kicks (reloads) the watchdog. The control register holds the unit selection and the timeout flag. When the counter runs out, the flag sets and the active-low output `wdt_n` goes low. Both stay so until software clears the flag or disables the watchdog. The prescaler division ratios are parameters, so a small configuration can run in few cycles.

Top module: `wdt_timebase`

## Requirements
- R1: After reset the count reads 0, the control register reads 0 (unit code 00, flag clear) and `wdt_n` is high.
- R2: A write to address 0 with a nonzero value loads the counter and starts it. A read of address 0 returns the remaining count.
- R3: While nonzero, the counter drops by exactly one per selected unit. Unit code 00 is TICK_DIV clocks, 01 is TICK_DIV*SEC_DIV clocks, and 10 and 11 are both TICK_DIV*SEC_DIV*MIN_DIV clocks.
- R4: After a load of N at clock edge E with unit length U clocks, the flag sets and `wdt_n` goes low at edge E+N*U and not before.
- R5: After expiry the counter holds at 0 and does not wrap. The flag and `wdt_n` low persist.
- R6: Writing address 1 with bit 2 set clears the flag and returns `wdt_n` high. Writing bit 2 as 0 leaves the flag unchanged.
- R7: Writing 0 to address 0 stops the counter at 0, clears the flag, returns `wdt_n` high, and no expiry follows.
- R8: A reload of the count restarts the unit phase, so the first decrement after a kick comes one full unit later.
- R9: A control write that changes the unit code restarts the unit phase without touching the count. A control write that keeps the same unit code leaves the phase alone.
- R10: A read of address 1 returns the unit code in bits 1:0 and the flag in bit 2, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 count, 1 control/status |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for the selected register |
| wdt_n | output | 1 | Timeout output, active low |

## Verification
On every cycle the assertions check the local rules. The counter only ever holds its value or steps down by one. It stays at zero unless loaded. An expiry event is always followed by the flag and a low output. A phase restart never yields a tick on the next cycle. The flag clear and the zero-count disable take effect one edge after the write. Only the bench's scenarios can show the exact expiry edge for each unit code and count. They also show the full-unit delay after a kick or a unit change, and that rewriting the same unit leaves the phase alone. For these, the bench sweeps counts and unit codes over a small prescaler configuration and works out each edge arithmetically.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    UNIT_FAST     = 2'b00,
    UNIT_MID      = 2'b01,
    UNIT_SLOW     = 2'b10,
    UNIT_SLOW_ALT = 2'b11
  } wdt_unit_e;

  localparam logic ADDR_COUNT   = 1'b0;
  localparam logic ADDR_CTRL    = 1'b1;
  localparam int   FLAG_BIT     = 2;
  localparam int   NUM_STAGES   = 3;

  // prescaler stage whose tick drives the counter for a given unit code
  function automatic int stage_of_unit(input logic [1:0] code);
    case (code)
      UNIT_FAST: return 0;
      UNIT_MID:  return 1;
      default:   return 2;
    endcase
  endfunction

  // division ratio of one stage of the chain
  function automatic int stage_ratio(input int idx, input int d0, input int d1, input int d2);
    if (idx == 0) return d0;
    if (idx == 1) return d1;
    return d2;
  endfunction

  function automatic int ratio_width(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 480000,
  parameter int SEC_DIV  = 100,
  parameter int MIN_DIV  = 60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  phase_clr,
  output logic [NUM_STAGES-1:0] stage_tick
);

  logic stage_en [NUM_STAGES+1];

  assign stage_en[0] = 1'b1;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    localparam int RATIO = stage_ratio(i, TICK_DIV, SEC_DIV, MIN_DIV);
    localparam int W     = ratio_width(RATIO);

    logic [W-1:0] phase;
    logic         at_end;

    assign at_end          = (phase == W'(RATIO - 1));
    assign stage_en[i+1]   = stage_en[i] & at_end;
    assign stage_tick[i]   = stage_en[i+1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        phase <= '0;
      end else if (phase_clr) begin
        phase <= '0;
      end else if (stage_en[i]) begin
        phase <= at_end ? '0 : phase + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             unit_tick,
  input  logic             clr_flag,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             expire_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic running;
  logic disable_wr;

  assign running    = (cnt != '0);
  assign disable_wr = load && (load_val == '0);
  assign expire_evt = !load && unit_tick && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (unit_tick && running) begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (expire_evt) begin
      flag <= 1'b1;
    end else if (disable_wr || clr_flag) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             flag,
  output logic [1:0]       unit,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             clr_flag,
  output logic             phase_clr,
  output logic [CNT_W-1:0] rdata
);

  logic ctrl_wr;
  logic unit_change;

  assign ctrl_wr     = we && (addr == ADDR_CTRL);
  assign load        = we && (addr == ADDR_COUNT);
  assign load_val    = wdata;
  assign unit_change = ctrl_wr && (wdata[1:0] != unit);
  assign clr_flag    = ctrl_wr && wdata[FLAG_BIT];
  assign phase_clr   = load || unit_change;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit <= UNIT_FAST;
    end else if (ctrl_wr) begin
      unit <= wdata[1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_COUNT) begin
      rdata = cnt;
    end else begin
      rdata[1:0]      = unit;
      rdata[FLAG_BIT] = flag;
    end
  end

endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 480000,
  parameter int SEC_DIV  = 100,
  parameter int MIN_DIV  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             wdt_n
);

  logic [NUM_STAGES-1:0] stage_tick;
  logic [1:0]            unit;
  logic                  load;
  logic [CNT_W-1:0]      load_val;
  logic                  clr_flag;
  logic                  phase_clr;
  logic                  unit_tick;
  logic [CNT_W-1:0]      cnt;
  logic                  flag;
  logic                  expire_evt;

  wdt_prescaler #(
    .TICK_DIV (TICK_DIV),
    .SEC_DIV  (SEC_DIV),
    .MIN_DIV  (MIN_DIV)
  ) u_prescaler (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_clr  (phase_clr),
    .stage_tick (stage_tick)
  );

  assign unit_tick = stage_tick[stage_of_unit(unit)];

  wdt_regs #(
    .CNT_W (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .cnt       (cnt),
    .flag      (flag),
    .unit      (unit),
    .load      (load),
    .load_val  (load_val),
    .clr_flag  (clr_flag),
    .phase_clr (phase_clr),
    .rdata     (reg_rdata)
  );

  wdt_countdown #(
    .CNT_W (CNT_W)
  ) u_countdown (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (load_val),
    .unit_tick  (unit_tick),
    .clr_flag   (clr_flag),
    .cnt        (cnt),
    .flag       (flag),
    .expire_evt (expire_evt)
  );

  assign wdt_n = !flag;

endmodule

// File: rtl/wdt_timebase_chk.sv
module wdt_timebase_chk #(
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 480000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic             addr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             wdt_n,
  input logic             expire_evt,
  input logic             phase_clr,
  input logic             unit_tick
);

  logic cnt_wr;
  logic ctrl_wr;
  assign cnt_wr  = we && !addr;
  assign ctrl_wr = we && addr;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !cnt_wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1)); // R3

  AST_EXPIRY_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (flag && !wdt_n)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !cnt_wr) |=> (cnt == '0)); // R5

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[2] && !expire_evt) |=> (!flag && wdt_n)); // R6

  AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && wdata == '0) |=> (cnt == '0 && wdt_n)); // R7

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_clr && TICK_DIV > 1) |=> !unit_tick); // R8

endmodule

bind wdt_timebase wdt_timebase_chk #(
  .CNT_W    (CNT_W),
  .TICK_DIV (TICK_DIV)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .we         (reg_we),
  .addr       (reg_addr),
  .wdata      (reg_wdata),
  .cnt        (cnt),
  .flag       (flag),
  .wdt_n      (wdt_n),
  .expire_evt (expire_evt),
  .phase_clr  (phase_clr),
  .unit_tick  (unit_tick)
);

// File: tb/wdt_timebase_test.sv
module wdt_timebase_test;

  localparam int CNT_W = 8;
  localparam int TD    = 4;
  localparam int SD    = 3;
  localparam int MD    = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic             reg_addr = 1'b0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic             wdt_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdt_timebase #(
    .CNT_W    (CNT_W),
    .TICK_DIV (TD),
    .SEC_DIV  (SD),
    .MIN_DIV  (MD)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wdt_n     (wdt_n)
  );

  function automatic int unit_len(input int code);
    if (code == 0) return TD;
    if (code == 1) return TD * SD;
    return TD * SD * MD;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one write; its edge is the next posedge, returns at the following negedge
  task automatic wr(input logic a, input logic [CNT_W-1:0] d);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic clean();
    wr(1'b0, '0);
    wr(1'b1, 8'h04);
  endtask

  initial begin
    int v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    rd(1'b0, v); check("R1", "count after reset", v, 0);
    rd(1'b1, v); check("R1", "ctrl after reset", v, 0);
    check("R1", "wdt_n after reset", int'(wdt_n), 1);

    // sweep of count and unit code: R2, R3, R4
    for (int u = 0; u < 4; u++) begin
      for (int n = 1; n <= 6; n++) begin
        int ulen;
        ulen = unit_len(u);
        wr(1'b0, '0);
        wr(1'b1, CNT_W'(u));
        wr(1'b0, CNT_W'(n));
        rd(1'b0, v); check("R2", "count just after load", v, n);
        if (n > 1) begin
          wait_cyc(ulen - 1);
          rd(1'b0, v); check("R3", "count before first unit ends", v, n);
          wait_cyc(1);
          rd(1'b0, v); check("R3", "count after first unit", v, n - 1);
          wait_cyc((n - 1) * ulen - 1);
        end else begin
          wait_cyc(ulen - 1);
        end
        rd(1'b0, v); check("R3", "count one cycle before expiry", v, 1);
        check("R4", "wdt_n one cycle before expiry", int'(wdt_n), 1);
        wait_cyc(1);
        rd(1'b1, v); check("R4", "flag at expiry edge", (v >> 2) & 1, 1);
        check("R4", "wdt_n at expiry edge", int'(wdt_n), 0);
      end
    end

    // R5 hold at zero after expiry
    wait_cyc(40);
    rd(1'b0, v); check("R5", "count held at zero", v, 0);
    check("R5", "wdt_n still low", int'(wdt_n), 0);
    rd(1'b1, v); check("R10", "ctrl read flag+unit 3", v, 8'h07);

    // R6 writing bit 2 as 0 keeps the flag, as 1 clears it
    wr(1'b1, 8'h03);
    rd(1'b1, v); check("R6", "flag kept by zero bit", (v >> 2) & 1, 1);
    check("R6", "wdt_n kept low", int'(wdt_n), 0);
    wr(1'b1, 8'h07);
    rd(1'b1, v); check("R6", "flag cleared by one bit", (v >> 2) & 1, 0);
    check("R6", "wdt_n released", int'(wdt_n), 1);

    // R7 zero count disables a running watchdog
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd3);
    wait_cyc(2);
    wr(1'b0, 8'd0);
    rd(1'b0, v); check("R7", "count after disable", v, 0);
    wait_cyc(40);
    check("R7", "no expiry after disable", int'(wdt_n), 1);
    // R7 zero count clears a set flag
    wr(1'b0, 8'd1);
    wait_cyc(TD);
    check("R7", "expired before disable", int'(wdt_n), 0);
    wr(1'b0, 8'd0);
    rd(1'b1, v); check("R7", "flag cleared by zero count", (v >> 2) & 1, 0);
    check("R7", "wdt_n released by zero count", int'(wdt_n), 1);

    // R8 kick restarts phase
    clean();
    wr(1'b0, 8'd2);
    wait_cyc(2);
    wr(1'b0, 8'd2);
    wait_cyc(2 * TD - 1);
    check("R8", "no expiry before full units after kick", int'(wdt_n), 1);
    wait_cyc(1);
    check("R8", "expiry full units after kick", int'(wdt_n), 0);

    // R9 unit change restarts phase, count untouched
    clean();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd3);
    wait_cyc(1);
    wr(1'b1, 8'h01);
    rd(1'b0, v); check("R9", "count untouched by unit change", v, 3);
    wait_cyc(3 * unit_len(1) - 1);
    check("R9", "no expiry before new unit span", int'(wdt_n), 1);
    wait_cyc(1);
    check("R9", "expiry after new unit span", int'(wdt_n), 0);

    // R9 same unit rewrite keeps phase
    clean();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd2);
    wait_cyc(1);
    wr(1'b1, 8'h00);
    wait_cyc(2 * TD - 3);
    check("R9", "same unit: not yet expired", int'(wdt_n), 1);
    wait_cyc(1);
    check("R9", "same unit: phase kept", int'(wdt_n), 0);

    // R10 unused control bits read zero
    clean();
    wr(1'b1, 8'hF9);
    rd(1'b1, v); check("R10", "ctrl read masks other bits", v, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule